// File: doc/BRIEF.md
# FIFO DMA Request and Panic Generator

This block sits beside the transmit and receive FIFOs of a streaming audio-style serial port and turns their fill levels into DMA request lines. Each direction has two outputs: a normal request and a panic request. The panic request asks the DMA engine for higher priority before the FIFO runs dry (transmit) or overflows (receive). Four byte-wide thresholds sit in one 32-bit threshold word. A single DMA enable gates all four request lines.

The block also builds the peripheral's status flags from the same levels and from the FIFO push and pop strobes:

- empty, full and has-data flags;
- needs-writing and needs-reading flags, each asserting at a coarse level chosen by a 2-bit selector;
- sticky underrun and overrun errors, cleared by writing 1.

A four-bit interrupt status is masked by an enable word and reduced to one interrupt line. The FIFO storage itself is outside the block. Every output is registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `fifo_dreq_gen`

## Requirements
- R1: While `rst_n` is low, all request lines, `stat_word`, `int_stat` and `irq` are 0.
- R2: `tx_dreq` is 1 one cycle after `dma_en`=1 and `tx_level` < `thr_word[15:8]`, and 0 when `tx_level` is at or above that field.
- R3: `tx_panic` is 1 one cycle after `dma_en`=1 and `tx_level` < `thr_word[31:24]`, and 0 otherwise.
- R4: `rx_dreq` is 1 one cycle after `dma_en`=1 and `rx_level` > `thr_word[7:0]`, and 0 when the level equals or is below that field.
- R5: `rx_panic` is 1 one cycle after `dma_en`=1 and `rx_level` > `thr_word[23:16]`, and 0 otherwise.
- R6: With `dma_en`=0, all four request lines are 0 one cycle later, whatever the levels are.
- R7: `stat_word` bits 22, 21, 20 and 19 report four level flags one cycle after the levels are sampled:
  - bit 22: receive full (`rx_level` = DEPTH);
  - bit 21: transmit empty (`tx_level` = 0);
  - bit 20: receive has data (`rx_level` ≠ 0);
  - bit 19: transmit has room (`tx_level` ≠ DEPTH).
- R8: `stat_word` bit 17 (transmit needs writing) is 1 when `tx_level` < L. L depends on `tx_sel`: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives 3·DEPTH/4.
- R9: `stat_word` bit 18 (receive needs reading) is 1 when `rx_level` ≥ M. M depends on `rx_sel`: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives DEPTH.
- R10: `stat_word` bit 15 (transmit error) is set by `tx_pop` while `tx_level` = 0. It stays set until a cycle with `err_clr[0]`=1 and no new underrun. A new underrun in the clearing cycle keeps it set.
- R11: `stat_word` bit 16 (receive error) is set by `rx_push` while `rx_level` = DEPTH. It stays set until a cycle with `err_clr[1]`=1 and no new overrun.
- R12: `int_stat` holds {receive error, transmit error, needs-reading, needs-writing} in bits 3..0. `irq` is the OR of `int_stat` ANDed with `int_en` sampled in the same cycle, and updates in the same cycle as `int_stat`.
- R13: Bits of `stat_word` other than 22..15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Gates all four request lines |
| thr_word | input | 32 | Thresholds: tx panic [31:24], rx panic [23:16], tx request [15:8], rx request [7:0] |
| tx_sel | input | 2 | Level choice for transmit needs-writing |
| rx_sel | input | 2 | Level choice for receive needs-reading |
| int_en | input | 4 | Interrupt enables, same bit layout as int_stat |
| err_clr | input | 2 | Write-1 clear: [1] receive error, [0] transmit error |
| tx_level | input | LVL_W (7) | Transmit FIFO fill level |
| rx_level | input | LVL_W (7) | Receive FIFO fill level |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| rx_push | input | 1 | Receive FIFO write strobe |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit high-priority request |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive high-priority request |
| stat_word | output | 32 | Status flags at bits 22..15 |
| int_stat | output | 4 | Raw interrupt status |
| irq | output | 1 | Masked interrupt line |

## Verification
The hardest conditions to reach are the error corners. An underrun or overrun needs a strobe to coincide with an empty or full level. A clear must coincide with a fresh error event so that the set-wins rule is visible. The bench drives the level ports directly to 0 or to DEPTH and pulses the strobe for exactly one cycle. It then stages a clearing cycle that carries another strobe, followed by a clean clearing cycle. Threshold boundaries are probed one level below, at, and one level above each byte field, with the reset-typical settings.

// File: rtl/fdg_pkg.sv
package fdg_pkg;

    // Bit layout of the status flags; it lands at stat_word[22:15].
    typedef struct packed {
        logic rx_full;   // 22
        logic tx_empty;  // 21
        logic rx_has;    // 20
        logic tx_room;   // 19
        logic rx_need;   // 18
        logic tx_need;   // 17
        logic rx_err;    // 16
        logic tx_err;    // 15
    } fdg_flags_t;

    localparam int FLAG_LSB = 15;

    // Registered outputs of the generator.
    typedef struct packed {
        logic       tx_dreq;
        logic       tx_panic;
        logic       rx_dreq;
        logic       rx_panic;
        fdg_flags_t flags;
        logic       irq;
    } fdg_out_t;

endpackage

// File: rtl/fdg_req_cmp.sv
module fdg_req_cmp #(
    parameter int LVL_W = 7,
    parameter bit IS_RX = 1'b0
) (
    input  logic [LVL_W-1:0] level,
    input  logic [7:0]       req_thr,
    input  logic [7:0]       pan_thr,
    input  logic             en,
    output logic             req,
    output logic             pan
);
    localparam int CW = (LVL_W > 8) ? LVL_W : 8;

    logic [CW-1:0] lv, rt, pt;

    assign lv = CW'(level);
    assign rt = CW'(req_thr);
    assign pt = CW'(pan_thr);

    generate
        if (IS_RX) begin : g_rx
            // Receive side asks for service when the level is above threshold.
            assign req = en && (lv > rt);
            assign pan = en && (lv > pt);
        end else begin : g_tx
            // Transmit side asks for data when the level is below threshold.
            assign req = en && (lv < rt);
            assign pan = en && (lv < pt);
        end
    endgenerate
endmodule

// File: rtl/fdg_level_flags.sv
module fdg_level_flags #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       tx_sel,
    input  logic [1:0]       rx_sel,
    // {rx_full, tx_empty, rx_has, tx_room, rx_need, tx_need}
    output logic [5:0]       lvl_flags
);
    localparam int XW = LVL_W + 1;
    localparam logic [XW-1:0] L_ONE  = XW'(1);
    localparam logic [XW-1:0] L_QTR  = XW'(DEPTH / 4);
    localparam logic [XW-1:0] L_HALF = XW'(DEPTH / 2);
    localparam logic [XW-1:0] L_3QTR = XW'((3 * DEPTH) / 4);
    localparam logic [XW-1:0] L_FULL = XW'(DEPTH);

    logic [XW-1:0] tx_x, rx_x, tx_lim, rx_lim;

    assign tx_x = {1'b0, tx_level};
    assign rx_x = {1'b0, rx_level};

    always_comb begin
        unique case (tx_sel)
            2'd0:    tx_lim = L_ONE;
            2'd1:    tx_lim = L_QTR;
            2'd2:    tx_lim = L_HALF;
            default: tx_lim = L_3QTR;
        endcase
        unique case (rx_sel)
            2'd0:    rx_lim = L_ONE;
            2'd1:    rx_lim = L_QTR;
            2'd2:    rx_lim = L_HALF;
            default: rx_lim = L_FULL;
        endcase
    end

    assign lvl_flags = {
        (rx_x == L_FULL),
        (tx_x == '0),
        (rx_x != '0),
        (tx_x != L_FULL),
        (rx_x >= rx_lim),
        (tx_x <  tx_lim)
    };
endmodule

// File: rtl/fdg_err_next.sv
module fdg_err_next (
    input  logic [1:0] err_q,   // [1] rx, [0] tx
    input  logic       tx_under,
    input  logic       rx_over,
    input  logic [1:0] clr,
    output logic [1:0] err_d
);
    // A fresh event wins over a clear in the same cycle.
    assign err_d = (err_q & ~clr) | {rx_over, tx_under};
endmodule

// File: rtl/fifo_dreq_gen.sv
module fifo_dreq_gen
    import fdg_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic [31:0]      thr_word,
    input  logic [1:0]       tx_sel,
    input  logic [1:0]       rx_sel,
    input  logic [3:0]       int_en,
    input  logic [1:0]       err_clr,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             tx_pop,
    input  logic             rx_push,
    output logic             tx_dreq,
    output logic             tx_panic,
    output logic             rx_dreq,
    output logic             rx_panic,
    output logic [31:0]      stat_word,
    output logic [3:0]       int_stat,
    output logic             irq
);
    localparam int NDIR = 2;   // 0 = transmit, 1 = receive
    localparam logic [LVL_W:0] FULL_X = (LVL_W + 1)'(DEPTH);
    localparam int HI_PAD = 32 - FLAG_LSB - $bits(fdg_flags_t);

    fdg_out_t st_d, st_q;

    logic [LVL_W-1:0] lvl_a [NDIR];
    logic [NDIR-1:0]  req_a, pan_a;
    logic [5:0]       lvl_flags;
    logic             tx_under, rx_over;
    logic [1:0]       err_d;
    logic [3:0]       istat_d;

    assign lvl_a[0] = tx_level;
    assign lvl_a[1] = rx_level;

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            localparam int REQ_LSB = (NDIR - 1 - g) * 8;
            localparam int PAN_LSB = 16 + (NDIR - 1 - g) * 8;
            fdg_req_cmp #(
                .LVL_W (LVL_W),
                .IS_RX (g == 1)
            ) u_cmp (
                .level   (lvl_a[g]),
                .req_thr (thr_word[REQ_LSB +: 8]),
                .pan_thr (thr_word[PAN_LSB +: 8]),
                .en      (dma_en),
                .req     (req_a[g]),
                .pan     (pan_a[g])
            );
        end
    endgenerate

    fdg_level_flags #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_flags (
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_sel    (tx_sel),
        .rx_sel    (rx_sel),
        .lvl_flags (lvl_flags)
    );

    assign tx_under = tx_pop && (tx_level == '0);
    assign rx_over  = rx_push && ({1'b0, rx_level} == FULL_X);

    fdg_err_next u_err (
        .err_q    ({st_q.flags.rx_err, st_q.flags.tx_err}),
        .tx_under (tx_under),
        .rx_over  (rx_over),
        .clr      (err_clr),
        .err_d    (err_d)
    );

    always_comb begin
        st_d = st_q;
        st_d.tx_dreq  = req_a[0];
        st_d.tx_panic = pan_a[0];
        st_d.rx_dreq  = req_a[1];
        st_d.rx_panic = pan_a[1];
        {st_d.flags.rx_full, st_d.flags.tx_empty, st_d.flags.rx_has,
         st_d.flags.tx_room, st_d.flags.rx_need, st_d.flags.tx_need} = lvl_flags;
        st_d.flags.rx_err = err_d[1];
        st_d.flags.tx_err = err_d[0];
        istat_d  = {err_d[1], err_d[0], lvl_flags[1], lvl_flags[0]};
        st_d.irq = |(istat_d & int_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_dreq   = st_q.tx_dreq;
    assign tx_panic  = st_q.tx_panic;
    assign rx_dreq   = st_q.rx_dreq;
    assign rx_panic  = st_q.rx_panic;
    assign stat_word = {{HI_PAD{1'b0}}, st_q.flags, {FLAG_LSB{1'b0}}};
    assign int_stat  = {st_q.flags.rx_err, st_q.flags.tx_err,
                        st_q.flags.rx_need, st_q.flags.tx_need};
    assign irq       = st_q.irq;

    // R6
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !(tx_dreq || tx_panic || rx_dreq || rx_panic));

    // R3
    tx_panic_low_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && tx_level == '0 && thr_word[31:24] != 8'd0) |=> tx_panic);

    // R10
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_level == '0) |=> int_stat[2]);

    // R10
    tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat[2] && !err_clr[0]) |=> int_stat[2]);

    // R11
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && {1'b0, rx_level} == FULL_X) |=> int_stat[3]);

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 4'd0) |=> !irq);

    // R13
    stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[31:23] == '0) && (stat_word[14:0] == '0));
endmodule

// File: tb/fifo_dreq_gen_bench.sv
module fifo_dreq_gen_bench;
    localparam int DEPTH = 64;
    localparam int LVL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dma_en = 1'b0;
    logic [31:0]      thr_word = 32'h1030_3020;
    logic [1:0]       tx_sel = 2'd0, rx_sel = 2'd0;
    logic [3:0]       int_en = 4'd0;
    logic [1:0]       err_clr = 2'd0;
    logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
    logic             tx_pop = 1'b0, rx_push = 1'b0;
    logic             tx_dreq, tx_panic, rx_dreq, rx_panic, irq;
    logic [31:0]      stat_word;
    logic [3:0]       int_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fifo_dreq_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo_dreq_gen (
        .clk, .rst_n, .dma_en, .thr_word, .tx_sel, .rx_sel, .int_en, .err_clr,
        .tx_level, .rx_level, .tx_pop, .rx_push,
        .tx_dreq, .tx_panic, .rx_dreq, .rx_panic, .stat_word, .int_stat, .irq
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge, then sample 1 ns later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        #1;
        check("R1 req", {tx_dreq, tx_panic, rx_dreq, rx_panic}, 0);
        check("R1 stat", stat_word, 0);
        check("R1 irq", {int_stat, irq}, 0);
        step();
        check("R1 held", stat_word, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_tx_req();
        dma_en = 1'b1; rx_level = '0;
        tx_level = 7'h20; step();
        check("R2 below req", tx_dreq, 1); check("R3 above panic", tx_panic, 0);
        tx_level = 7'h30; step();
        check("R2 at req", tx_dreq, 0);
        tx_level = 7'h2F; step();
        check("R2 one below", tx_dreq, 1);
        tx_level = 7'h10; step();
        check("R3 at panic", tx_panic, 0);
        tx_level = 7'h0F; step();
        check("R3 below panic", {tx_dreq, tx_panic}, 2'b11);
    endtask

    task automatic t_rx_req();
        tx_level = 7'h30;
        rx_level = 7'h20; step();
        check("R4 at req", rx_dreq, 0);
        rx_level = 7'h21; step();
        check("R4 above req", rx_dreq, 1);
        rx_level = 7'h30; step();
        check("R5 at panic", {rx_dreq, rx_panic}, 2'b10);
        rx_level = 7'h31; step();
        check("R5 above panic", {rx_dreq, rx_panic}, 2'b11);
    endtask

    task automatic t_gate();
        dma_en = 1'b0; tx_level = '0; rx_level = 7'd64; step();
        check("R6 gated", {tx_dreq, tx_panic, rx_dreq, rx_panic}, 0);
        dma_en = 1'b1; step();
        check("R6 open", {tx_dreq, tx_panic, rx_dreq, rx_panic}, 4'hF);
        dma_en = 1'b0;
    endtask

    task automatic t_levels();
        tx_level = '0; rx_level = 7'd64; step();
        check("R7 empty/full", stat_word[22:19], 4'b1111);
        tx_level = 7'd64; rx_level = '0; step();
        check("R7 full/empty", stat_word[22:19], 4'b0000);
        tx_level = 7'd5; rx_level = 7'd5; step();
        check("R7 mid", stat_word[22:19], 4'b0011);
        check("R13 pad", {stat_word[31:23], stat_word[14:0]}, 0);
    endtask

    task automatic t_tx_need();
        int lim [4] = '{1, 16, 32, 48};
        rx_level = '0;
        for (int s = 0; s < 4; s++) begin
            tx_sel = 2'(s);
            tx_level = 7'(lim[s] - 1); step();
            check("R8 below limit", stat_word[17], 1);
            tx_level = 7'(lim[s]); step();
            check("R8 at limit", stat_word[17], 0);
        end
        tx_sel = 2'd0;
    endtask

    task automatic t_rx_need();
        int lim [4] = '{1, 16, 32, 64};
        tx_level = 7'd5;
        for (int s = 0; s < 4; s++) begin
            rx_sel = 2'(s);
            rx_level = 7'(lim[s] - 1); step();
            check("R9 below limit", stat_word[18], 0);
            rx_level = 7'(lim[s]); step();
            check("R9 at limit", stat_word[18], 1);
        end
        rx_sel = 2'd0;
    endtask

    task automatic t_tx_err();
        rx_level = '0;
        tx_level = 7'd1; tx_pop = 1'b1; step();
        check("R10 pop nonempty", stat_word[15], 0);
        tx_level = '0; step();
        check("R10 underrun", stat_word[15], 1);
        tx_pop = 1'b0; tx_level = 7'd5; step(); step(); step();
        check("R10 sticky", stat_word[15], 1);
        tx_level = '0; tx_pop = 1'b1; err_clr = 2'b01; step();
        check("R10 set wins", stat_word[15], 1);
        tx_pop = 1'b0; step();
        check("R10 cleared", stat_word[15], 0);
        err_clr = 2'b00; step();
        check("R10 stays clear", stat_word[15], 0);
    endtask

    task automatic t_rx_err();
        tx_level = 7'd5;
        rx_level = 7'd63; rx_push = 1'b1; step();
        check("R11 push not full", stat_word[16], 0);
        rx_level = 7'd64; step();
        check("R11 overrun", stat_word[16], 1);
        rx_push = 1'b0; err_clr = 2'b01; step();
        check("R11 wrong clear", stat_word[16], 1);
        err_clr = 2'b10; step();
        check("R11 cleared", stat_word[16], 0);
        err_clr = 2'b00; rx_level = '0;
    endtask

    task automatic t_irq();
        int_en = 4'd0; tx_level = '0; rx_level = '0; step();
        check("R12 raw status", int_stat, 4'b0001);
        check("R12 masked", irq, 0);
        int_en = 4'b0001; step();
        check("R12 enabled", irq, 1);
        int_en = 4'b1110; step();
        check("R12 other enables", irq, 0);
        rx_level = 7'd64; rx_push = 1'b1; step();
        rx_push = 1'b0;
        check("R12 rx err status", int_stat, 4'b1011);
        check("R12 rx err irq", irq, 1);
        err_clr = 2'b10; rx_level = '0; step();
        err_clr = 2'b00;
        check("R12 after clear", {int_stat, irq}, 5'b0001_0);
    endtask

    initial begin
        t_reset();
        t_tx_req();
        t_rx_req();
        t_gate();
        t_levels();
        t_tx_need();
        t_rx_need();
        t_tx_err();
        t_rx_err();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(4 * 20000);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule